// File: doc/BRIEF.md
# Staged-Response Watchdog Timer

This block is a down-counting watchdog that runs on the peripheral bus clock. Software sets it up through one control word. That word holds an enable flag, a response-mode flag and a read-only pulse-length code fixed at build time. Once enabled, the counter must be restarted by a kick before it reaches zero. When it is not restarted, the block reacts in one of two ways. In direct mode it drives a system reset pulse. In staged mode it first raises an interrupt, and it escalates to a reset only if that interrupt is still pending at the following expiry.

The counter reloads itself each time it expires, so a second expiry is always detected without help from software. Software cannot stop the block once it is running, because the enable flag is sticky until the block's own reset input is asserted. The reset pulse always runs for its programmed number of cycles.

Top module: `wdog_staged`

## Requirements
- R1: After `rst`, `reg_rdata` reads 0 except bits 4:2, which hold the pulse code. `irq` and `sys_rst` are both 0.
- R2: In `reg_rdata`, bit 0 is the enable flag and bit 1 is the mode (0 = direct, 1 = staged). Bits 4:2 always show the `RPL` parameter, and bits 31:5 always read 0. A write (`reg_we`) loads `reg_wdata[1]` into the mode, and the pulse code has no write path.
- R3: A write with `reg_wdata[0]`=1 sets the enable flag. A write with `reg_wdata[0]`=0 leaves the flag unchanged, and only `rst` clears it.
- R4: While the enable flag is 0, the counter keeps its value and no interrupt or reset is produced.
- R5: A kick reloads the counter to `TIMEOUT`. The first expiry after that shows on the outputs at the clock edge `TIMEOUT`+1 edges after the kick was sampled.
- R6: In direct mode, an expiry starts a reset pulse and never raises `irq`.
- R7: In staged mode, an expiry with no interrupt pending raises `irq` and does not start a reset.
- R8: In staged mode, an expiry while `irq` is still pending starts a reset pulse, and `irq` stays high.
- R9: `irq_clr` lowers `irq` at the next edge and does not reload the counter. An expiry sampled in the same cycle as a clear counts as a first expiry.
- R10: A reset pulse holds `sys_rst` high for exactly 2^(`RPL`+1) cycles.
- R11: While a pulse is running, kicks, clears and new expiries neither shorten it nor restart it.
- R12: When the counter reaches zero, it reloads itself and goes on counting. Without kicks, expiries therefore repeat every `TIMEOUT`+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 2 | Writable fields: bit 0 enable, bit 1 mode |
| reg_rdata | output | 32 | Control word read value |
| kick | input | 1 | Counter restart |
| irq_clr | input | 1 | Clears the pending interrupt |
| irq | output | 1 | Interrupt from the first expiry in staged mode |
| sys_rst | output | 1 | System reset pulse |

## Verification
The assertions check several properties on every cycle. They check the fixed layout of the read word and the stickiness of the enable flag. They check that nothing happens while the block is disabled, that direct mode never raises the interrupt, and that a clear always drops it. They also check that every reset pulse, once started, lasts exactly its programmed length. Other behaviour can only be shown by the bench's scenarios, compared against its cycle model: expiry timing relative to kicks, the self-reload period, and escalation from interrupt to reset. The same holds for a clear that does not restart the count, and for a kick storm that keeps the block silent.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int RD_W  = 32;
    localparam int WR_W  = 2;
    localparam int CODE_W = 3;

    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_STAGED = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  en;
    } ctrl_t;

    typedef enum logic {
        ST_ARMED  = 1'b0,
        ST_WARNED = 1'b1
    } resp_state_e;

    // Pulse length in cycles for a given code: 2^(code+1)
    function automatic int pulse_cycles(input logic [CODE_W-1:0] code);
        return 2 << code;
    endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import wdog_pkg::*;
#(
    parameter logic [CODE_W-1:0] RPL = 3'd2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [WR_W-1:0] wdata,
    output ctrl_t           ctrl,
    output logic [RD_W-1:0] rdata
);
    localparam int PAD_W = RD_W - CODE_W - WR_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.en   <= 1'b0;
            ctrl.mode <= MODE_DIRECT;
        end else if (we) begin
            // enable can only be set; a zero leaves it as it is
            ctrl.en   <= ctrl.en | wdata[0];
            ctrl.mode <= mode_e'(wdata[1]);
        end
    end

    assign rdata = {{PAD_W{1'b0}}, RPL, ctrl.mode, ctrl.en};

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W   = 16,
    parameter int TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic kick,
    output logic tmo
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT);

    logic [CNT_W-1:0] cnt;
    logic             at_zero;

    assign at_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || kick) begin
            cnt <= RELOAD;
        end else if (en) begin
            if (at_zero) cnt <= RELOAD;
            else         cnt <= cnt - 1'b1;
        end
    end

    assign tmo = en && !kick && at_zero;

endmodule

// File: rtl/wdog_response.sv
module wdog_response
    import wdog_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tmo,
    input  mode_e mode,
    input  logic  irq_clr,
    output logic  irq,
    output logic  fire
);
    resp_state_e state, state_nxt;
    logic        warned_live;

    always_comb begin
        warned_live = (state == ST_WARNED) && !irq_clr;
        state_nxt   = warned_live ? ST_WARNED : ST_ARMED;
        fire        = 1'b0;
        if (tmo) begin
            if (mode == MODE_DIRECT) begin
                fire = 1'b1;
            end else if (warned_live) begin
                fire = 1'b1;
            end else begin
                state_nxt = ST_WARNED;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_ARMED;
        else     state <= state_nxt;
    end

    assign irq = (state == ST_WARNED);

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
    import wdog_pkg::*;
#(
    parameter logic [CODE_W-1:0] RPL = 3'd2
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    localparam int            LEN   = pulse_cycles(RPL);
    localparam int            W     = $clog2(LEN + 1);
    localparam logic [W-1:0]  LEN_V = W'(LEN);

    logic [W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (left != '0) begin
            left <= left - 1'b1;
        end else if (fire) begin
            left <= LEN_V;
        end
    end

    assign pulse = (left != '0);

endmodule

// File: rtl/wdog_staged.sv
module wdog_staged
    import wdog_pkg::*;
#(
    parameter int                CNT_W   = 16,
    parameter int                TIMEOUT = 1000,
    parameter logic [CODE_W-1:0] RPL     = 3'd2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [WR_W-1:0] reg_wdata,
    output logic [RD_W-1:0] reg_rdata,
    input  logic            kick,
    input  logic            irq_clr,
    output logic            irq,
    output logic            sys_rst
);
    ctrl_t ctrl;
    logic  tmo_evt;
    logic  fire;

    wdog_ctrl_reg #(.RPL(RPL)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .wdata (reg_wdata),
        .ctrl  (ctrl),
        .rdata (reg_rdata)
    );

    wdog_counter #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .en   (ctrl.en),
        .kick (kick),
        .tmo  (tmo_evt)
    );

    wdog_response u_resp (
        .clk     (clk),
        .rst     (rst),
        .tmo     (tmo_evt),
        .mode    (ctrl.mode),
        .irq_clr (irq_clr),
        .irq     (irq),
        .fire    (fire)
    );

    wdog_pulse #(.RPL(RPL)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .pulse (sys_rst)
    );

endmodule

// File: rtl/wdog_staged_chk.sv
module wdog_staged_chk
    import wdog_pkg::*;
#(
    parameter logic [CODE_W-1:0] RPL = 3'd2
) (
    input logic            clk,
    input logic            rst,
    input logic [RD_W-1:0] reg_rdata,
    input logic            irq,
    input logic            irq_clr,
    input logic            sys_rst,
    input logic            tmo
);
    localparam logic [9:0] LEN_V = 10'(pulse_cycles(RPL));

    logic [9:0] run;

    always_ff @(posedge clk) begin
        if (rst)          run <= '0;
        else if (sys_rst) run <= run + 1'b1;
        else              run <= '0;
    end

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[RD_W-1:5] == '0);                                  // R2
    AST_CODE_FIXED: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[4:2] == RPL);                                      // R2
    AST_EN_STICKY: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[0] |=> reg_rdata[0]);                              // R3
    AST_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata[0] |=> !$rose(irq));                              // R4
    AST_OFF_NO_RST: assert property (@(posedge clk) disable iff (rst)
        (!reg_rdata[0] && !sys_rst) |=> !sys_rst);                   // R4
    AST_TMO_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        tmo |-> reg_rdata[0]);                                       // R4
    AST_DIRECT_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (!reg_rdata[1] && !irq) |=> !irq);                           // R6
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !tmo) |=> !irq);                                 // R9
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        (!sys_rst && run != '0) |-> run == LEN_V);                   // R10
    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst) |=> sys_rst);                                 // R11

endmodule

bind wdog_staged wdog_staged_chk #(.RPL(RPL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .irq_clr   (irq_clr),
    .sys_rst   (sys_rst),
    .tmo       (tmo_evt)
);

// File: tb/sim_wdog_staged.sv
`timescale 1ns/1ps
module sim_wdog_staged;

    localparam int          T    = 20;
    localparam logic [2:0]  CODE = 3'd2;
    localparam int          LEN  = 2 << CODE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        kick = 1'b0;
    logic        irq_clr = 1'b0;
    logic        irq;
    logic        sys_rst;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    wdog_staged #(.CNT_W(8), .TIMEOUT(T), .RPL(CODE)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .kick(kick), .irq_clr(irq_clr),
        .irq(irq), .sys_rst(sys_rst)
    );

    // behavioural reference
    bit m_en, m_mode, m_irq;
    int m_cnt, m_left;

    always @(posedge clk) begin
        bit expire, fire, nirq;
        if (rst) begin
            m_en = 0; m_mode = 0; m_irq = 0; m_cnt = T; m_left = 0;
        end else begin
            expire = m_en && !kick && (m_cnt == 0);
            fire   = 0;
            nirq   = m_irq && !irq_clr;
            if (expire) begin
                if (!m_mode)  fire = 1;
                else if (nirq) fire = 1;
                else nirq = 1;
            end
            if (kick) m_cnt = T;
            else if (m_en) m_cnt = (m_cnt == 0) ? T : m_cnt - 1;
            if (m_left > 0) m_left = m_left - 1;
            else if (fire) m_left = LEN;
            m_irq = nirq;
            if (reg_we) begin
                m_en   = m_en | reg_wdata[0];
                m_mode = reg_wdata[1];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_word();
        return {27'b0, CODE, m_mode, m_en};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
        if (!rst) begin
            chk(irq === m_irq, "R7 irq vs model", {31'b0, irq}, {31'b0, m_irq});
            chk(sys_rst === (m_left != 0), "R6 sys_rst vs model",
                {31'b0, sys_rst}, {31'b0, m_left != 0});
            chk(reg_rdata === m_word(), "R2 rdata vs model", reg_rdata, m_word());
        end
        kick = 0; irq_clr = 0; reg_we = 0;
    endtask

    task automatic wr(input logic [1:0] v);
        reg_we = 1; reg_wdata = v;
        step();
    endtask

    initial begin
        #(150000 * 5);
        n_err++;
        $display("FAIL watchdog: run hung act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int  n;
        bit  seen;
        repeat (3) step();
        rst = 0;
        step();
        // R1 reset state
        chk(reg_rdata === 32'h08, "R1 rdata after reset", reg_rdata, 32'h08);
        chk({irq, sys_rst} === 2'b00, "R1 outputs after reset", {30'b0, irq, sys_rst}, 0);

        // R2 mode written, enable left clear
        wr(2'b10);
        chk(reg_rdata === 32'h0A, "R2 mode bit", reg_rdata, 32'h0A);
        wr(2'b00);
        chk(reg_rdata === 32'h08, "R2 mode cleared", reg_rdata, 32'h08);

        // R4 disabled: silent and counter held
        seen = 0;
        repeat (60) begin step(); seen |= irq | sys_rst; end
        chk(!seen, "R4 quiet while disabled", {31'b0, seen}, 0);

        wr(2'b01);
        chk(reg_rdata[0] === 1'b1, "R3 enable set", {31'b0, reg_rdata[0]}, 1);
        n = 0;
        do begin step(); n++; end while (!sys_rst && n < 200);
        chk(n == T + 1, "R4 full count after enable", n, T + 1);
        chk(irq === 1'b0, "R6 no irq in direct mode", {31'b0, irq}, 0);

        // R12 self reload period, R10 pulse width
        n = 0;
        do begin step(); n++; end while (sys_rst && n < 400);
        chk(n == LEN, "R10 pulse width", n, LEN);
        do begin step(); n++; end while (!sys_rst && n < 400);
        chk(n == T + 1, "R12 expiry period", n, T + 1);

        // R11 pulse not cut by kicks and clears
        n = 1;
        while (n < 400) begin
            kick = 1; irq_clr = 1;
            step();
            if (!sys_rst) break;
            n++;
        end
        chk(n == LEN, "R11 pulse width under kicks", n, LEN);

        // R3 zero write keeps enable
        wr(2'b00);
        chk(reg_rdata[0] === 1'b1, "R3 enable sticky", {31'b0, reg_rdata[0]}, 1);

        // staged mode with kick
        reg_we = 1; reg_wdata = 2'b11; kick = 1;
        step();
        n = 0;
        do begin step(); n++; end while (!irq && n < 200);
        chk(n == T + 1, "R5 expiry after kick", n, T + 1);
        chk(sys_rst === 1'b0, "R7 warning only", {31'b0, sys_rst}, 0);

        irq_clr = 1;
        step();
        chk(irq === 1'b0, "R9 clear drops irq", {31'b0, irq}, 0);
        n = 0;
        do begin step(); n++; end while (!irq && n < 200);
        chk(n == T, "R9 clear does not reload", n, T);
        chk(sys_rst === 1'b0, "R9 rewarn not reset", {31'b0, sys_rst}, 0);

        n = 0;
        do begin step(); n++; end while (!sys_rst && n < 200);
        chk(n == T + 1, "R8 escalation timing", n, T + 1);
        chk(irq === 1'b1, "R8 irq held", {31'b0, irq}, 1);

        while (sys_rst) step();
        irq_clr = 1;
        step();
        // R5 regular kicks keep it silent
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            if (i % 10 == 0) kick = 1;
            step();
            seen |= irq | sys_rst;
        end
        chk(!seen, "R5 kicks prevent expiry", {31'b0, seen}, 0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule